// File: doc/BRIEF.md
# Prescaled Scanline Interrupt Counter

This block raises an interrupt for a cartridge bank controller. It runs once per CPU cycle: each cycle the system asserts a cycle-enable strobe. An 8-bit up-counter advances on ticks. When it passes 0xFF, it loads the value held in a programmable 8-bit reload latch and sets a level interrupt line. The line then stays high until software clears it.

There are two counting modes. In cycle mode, every enabled CPU cycle is a tick. In scanline mode, a signed fractional prescaler turns CPU cycles into ticks. On each cycle it subtracts 3. When the result is zero or below, it adds 341 back and issues a tick. This gives about one tick per video scanline.

Software reaches the block through four write slots, selected by a 2-bit slot number: reload-latch low nibble, reload-latch high nibble, control, and acknowledge. The acknowledge slot clears the interrupt. It also restores the enable bit from a value saved by the last control write.

Top module: `lineirq_gen`

## Requirements
- R1: A synchronous reset clears the reload latch, mode, enable, saved acknowledge bit, counter, prescaler and `irq`. After reset, an enable with no latch write counts 256 ticks before the first interrupt.
- R2: A write to slot 0 replaces latch bits 3:0 with `wr_data[3:0]`. A write to slot 1 replaces latch bits 7:4 with `wr_data[3:0]`. Bits 7:4 of `wr_data` are ignored.
- R3: A write to slot 2 (control) sets the mode from bit 2 (1 = cycle mode, 0 = scanline mode), the enable from bit 1, and the saved acknowledge bit from bit 0. If bit 1 is set, the counter reloads from the latch and the prescaler is preset to 341.
- R4: Any write to slot 2 or slot 3 drives `irq` low at the next clock edge. Otherwise `irq`, once high, stays high.
- R5: A write to slot 3 (acknowledge) copies the saved acknowledge bit into the enable bit. It does not reload the counter.
- R6: On a tick, a counter value of 0xFF reloads from the latch and `irq` goes high at that same clock edge. Any other value increments by one.
- R7: In cycle mode, every cycle with `cyc_en` high and the enable set is a tick.
- R8: In scanline mode, each counting cycle subtracts 3 from the prescaler. When the result is at most zero, 341 is added and a tick is issued. The prescaler always stays within -2 to 341.
- R9: With the enable clear or `cyc_en` low, the counter and prescaler do not change.
- R10: A cycle that writes slot 2 or slot 3 does not count; the write takes effect instead. A latch write in a counting cycle does not stop counting, and a wrap in that cycle reloads the old latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | One CPU cycle elapses this clock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Slot: 0 latch low, 1 latch high, 2 control, 3 acknowledge |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Registered level interrupt |

## Verification
The checker assumes that at most one slot is written per clock. This holds by construction, because there is a single write strobe with one slot number. The checker also assumes that a write and a CPU cycle may coincide, and that the design must then follow the write-wins rule. The stimulus drives one write per cycle and deliberately combines writes with `cyc_en`. It only asserts reset on clock-aligned cycles, so the reset-driven properties see clean edges. Every other cycle carries an expected interrupt level from a cycle-accurate model.

// File: rtl/lineirq_pkg.sv
package lineirq_pkg;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 8;
  localparam int PS_W   = 10;
  localparam int HALF_W = CNT_W / 2;

  typedef enum logic [1:0] {
    SLOT_LATCH_LO = 2'd0,
    SLOT_LATCH_HI = 2'd1,
    SLOT_CTRL     = 2'd2,
    SLOT_ACK      = 2'd3
  } slot_e;

  typedef enum logic {
    MODE_LINE  = 1'b0,
    MODE_CYCLE = 1'b1
  } mode_e;
endpackage

// File: rtl/lineirq_regs.sv
module lineirq_regs
  import lineirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  latch_q,
  output mode_e             mode_q,
  output logic              en_q,
  output logic              ctrl_wr,
  output logic              ack_wr,
  output logic              arm
);
  logic saved_ack_q;

  assign ctrl_wr = wr_en && (slot_e'(wr_sel) == SLOT_CTRL);
  assign ack_wr  = wr_en && (slot_e'(wr_sel) == SLOT_ACK);
  assign arm     = ctrl_wr && wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q     <= '0;
      mode_q      <= MODE_LINE;
      en_q        <= 1'b0;
      saved_ack_q <= 1'b0;
    end else if (wr_en) begin
      unique case (slot_e'(wr_sel))
        SLOT_LATCH_LO: latch_q[HALF_W-1:0]     <= wr_data[HALF_W-1:0];
        SLOT_LATCH_HI: latch_q[CNT_W-1:HALF_W] <= wr_data[HALF_W-1:0];
        SLOT_CTRL: begin
          mode_q      <= mode_e'(wr_data[2]);
          en_q        <= wr_data[1];
          saved_ack_q <= wr_data[0];
        end
        SLOT_ACK: en_q <= saved_ack_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lineirq_prescaler.sv
module lineirq_prescaler
  import lineirq_pkg::*;
#(
  parameter int STEP   = 3,
  parameter int PERIOD = 341
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   preset,
  input  logic                   run,
  output logic                   tick,
  output logic signed [PS_W-1:0] ps_q
);
  localparam logic signed [PS_W-1:0] STEP_V   = PS_W'(STEP);
  localparam logic signed [PS_W-1:0] PERIOD_V = PS_W'(PERIOD);

  logic signed [PS_W-1:0] diff;

  assign diff = ps_q - STEP_V;
  assign tick = run && (diff <= 0);

  always_ff @(posedge clk) begin
    if (rst)         ps_q <= '0;
    else if (preset) ps_q <= PERIOD_V;
    else if (run)    ps_q <= (diff <= 0) ? diff + PERIOD_V : diff;
  end
endmodule

// File: rtl/lineirq_counter.sv
module lineirq_counter
  import lineirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] latch,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  assign wrap = tick && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= latch;
    else if (wrap) cnt_q <= latch;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lineirq_gen.sv
module lineirq_gen
  import lineirq_pkg::*;
#(
  parameter int STEP   = 3,
  parameter int PERIOD = 341
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);
  logic [CNT_W-1:0]       latch_w;
  logic [CNT_W-1:0]       count_w;
  logic signed [PS_W-1:0] ps_w;
  mode_e                  mode_w;
  logic                   en_w;
  logic                   ctrl_wr, ack_wr, arm;
  logic                   counting, line_tick, tick, wrap;

  lineirq_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .latch_q(latch_w), .mode_q(mode_w), .en_q(en_w),
    .ctrl_wr(ctrl_wr), .ack_wr(ack_wr), .arm(arm)
  );

  assign counting = cyc_en && en_w && !ctrl_wr && !ack_wr;

  lineirq_prescaler #(.STEP(STEP), .PERIOD(PERIOD)) u_ps (
    .clk(clk), .rst(rst), .preset(arm),
    .run(counting && (mode_w == MODE_LINE)),
    .tick(line_tick), .ps_q(ps_w)
  );

  assign tick = (counting && (mode_w == MODE_CYCLE)) || line_tick;

  lineirq_counter u_cnt (
    .clk(clk), .rst(rst), .load(arm), .tick(tick), .latch(latch_w),
    .cnt_q(count_w), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)                    irq <= 1'b0;
    else if (ctrl_wr || ack_wr) irq <= 1'b0;
    else if (wrap)              irq <= 1'b1;
  end
endmodule

// File: rtl/lineirq_gen_chk.sv
module lineirq_gen_chk
  import lineirq_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [1:0]             wr_sel,
  input logic                   irq,
  input logic                   en,
  input logic [CNT_W-1:0]       count,
  input logic [CNT_W-1:0]       latch,
  input logic signed [PS_W-1:0] ps
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!irq && count == '0 && ps == '0));

  p_write_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel[1]) |=> !irq);

  p_irq_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (irq && !(wr_en && wr_sel[1])) |=> irq);

  p_rise_reloads_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (count == $past(latch)));

  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (!en && !(wr_en && wr_sel == 2'd2)) |=> ($stable(count) && $stable(ps)));

  p_ps_range_r8: assert property (@(posedge clk) disable iff (rst)
    (ps >= -2 && ps <= 341));
endmodule

bind lineirq_gen lineirq_gen_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .irq(irq),
  .en(en_w), .count(count_w), .latch(latch_w), .ps(ps_w)
);

// File: tb/lineirq_gen_test.sv
module lineirq_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       irq;

  always #5 clk = ~clk;

  lineirq_gen uut (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq)
  );

  typedef struct { logic exp; string req; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  string cur_req = "R1";

  // reference model state
  int m_latch = 0, m_cnt = 0, m_ps = 0;
  bit m_mode = 0, m_en = 0, m_ack = 0, m_irq = 0;

  task automatic cyc(input bit r, input bit e, input bit w,
                     input logic [1:0] s, input logic [7:0] d);
    bit tick;
    item_t it;
    @(negedge clk);
    rst = r; cyc_en = e; wr_en = w; wr_sel = s; wr_data = d;
    if (r) begin
      m_latch = 0; m_cnt = 0; m_ps = 0; m_mode = 0; m_en = 0; m_ack = 0; m_irq = 0;
    end else begin
      tick = 0;
      if (e && m_en && !(w && s[1])) begin       // R10 write-wins
        if (m_mode) tick = 1;                      // R7
        else begin                                 // R8
          m_ps = m_ps - 3;
          if (m_ps <= 0) begin m_ps = m_ps + 341; tick = 1; end
        end
      end
      if (tick) begin                              // R6
        if (m_cnt == 255) begin m_cnt = m_latch; m_irq = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (w) begin
        case (s)
          2'd0: m_latch = (m_latch & 'hF0) | int'(d[3:0]);          // R2
          2'd1: m_latch = (m_latch & 'h0F) | (int'(d[3:0]) << 4);   // R2
          2'd2: begin                                                // R3
            m_mode = d[2]; m_en = d[1]; m_ack = d[0];
            if (d[1]) begin m_cnt = m_latch; m_ps = 341; end
            m_irq = 0;
          end
          default: begin m_en = m_ack; m_irq = 0; end                // R5
        endcase
      end
    end
    it.exp = m_irq; it.req = cur_req;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input bit e);
    for (int i = 0; i < n; i++) cyc(0, e, 0, 2'd0, 8'd0);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d, input bit e);
    cyc(0, e, 1, s, d);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    item_t it;
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (irq !== it.exp) begin
        fails++;
        $display("FAIL %s: irq actual=%b expected=%b at %0t", it.req, irq, it.exp, $time);
      end
    end
  end

  bit finished = 0;
  initial begin
    #1_500_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R1"; for (int i = 0; i < 3; i++) cyc(1, 0, 0, 2'd0, 8'd0);
    idle(4, 1);
    cur_req = "R2"; wr(2'd0, 8'hAD, 0); wr(2'd1, 8'h5F, 0);   // latch 0xFD
    cur_req = "R7"; wr(2'd2, 8'h06, 0); idle(6, 1);
    cur_req = "R4"; idle(8, 1); wr(2'd3, 8'h00, 0);           // clears, enable=0
    cur_req = "R9"; idle(20, 1);
    cur_req = "R5"; wr(2'd2, 8'h05, 0); idle(5, 1); wr(2'd3, 8'h00, 0); idle(12, 1);
    cur_req = "R10"; wr(2'd0, 8'h01, 1); idle(4, 1); wr(2'd2, 8'h06, 1); idle(3, 1);
    wr(2'd3, 8'h00, 1); idle(6, 1);
    cur_req = "R8"; wr(2'd0, 8'h0E, 0); wr(2'd1, 8'h0F, 0); wr(2'd2, 8'h02, 0);
    idle(150, 1); idle(40, 0); idle(200, 1); idle(10, 0);
    cur_req = "R6"; wr(2'd2, 8'h06, 0); idle(8, 1);
    cur_req = "R3"; wr(2'd2, 8'h00, 1); idle(20, 1);
    cur_req = "R1"; wr(2'd1, 8'h0F, 0); wr(2'd0, 8'h0F, 0); wr(2'd2, 8'h06, 0); idle(2, 1);
    cyc(1, 1, 0, 2'd0, 8'd0); cyc(1, 1, 0, 2'd0, 8'd0);
    idle(10, 1); wr(2'd2, 8'h06, 0); idle(262, 1);
    @(posedge clk); #4;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule